// File: doc/BRIEF.md
# Flash write-buffer program unit

This unit carries out the buffered-program sequence of a parallel NOR flash that uses the common Intel-style command set. The outer command decoder hands the bus write port to the unit. A write of the buffered-program opcode 0xE8 while the unit is idle starts a sequence. The next bus write supplies a word count and an address. The address selects an aligned block, which is copied from the flash array into a local shadow buffer. After that, exactly count+1 data writes are merged into the shadow copy, and one more write acts as the confirm.

A confirm of 0xD0 with no programming error pending writes the whole shadow block back to the array, one word per clock. Any other confirm value, or an error that is already pending, drops the shadow copy and returns the unit to idle, which lets the outer decoder go back to array reads. While the snapshot or the write-back is running, the unit reports busy, clears the ready bit of its status byte and ignores bus writes. The array port has a one-cycle registered read latency.

The block size is 2^8 bytes for a one-byte bank and 2^11 bytes for wider banks, multiplied by the number of devices in parallel, and measured in bank words. The count is the low bits of the bus data: the device width, or the bank width when no device width is given.

Top module: `flash_wbuf_prog`

## Requirements
- R1: After reset the unit is idle (`seq_idle`=1), `status` reads 0x80 and neither `arr_re` nor `arr_we` is asserted.
- R2: While idle, only a bus write whose low byte is 0xE8 starts a sequence. Any other value leaves `seq_idle` high and causes no array access.
- R3: The bus write that follows 0xE8 gives the count (the low CNT_W bits of `bus_wdata`) and the block base (`bus_addr` with its low IDX_W bits cleared). On the next clock the unit issues DEPTH array reads in ascending address order from the base, one per clock, and then takes one more busy cycle to capture the last word.
- R4: Exactly count+1 bus writes are taken as data after the snapshot. Only the write after those is treated as the confirm, even if an earlier data value equals 0xD0.
- R5: A data write whose address lies outside the buffered block sets status bit 4 and changes no buffered word.
- R6: A data write while `ro_lock` is high sets status bit 4 and changes no buffered word.
- R7: A confirm of 0xD0 while status bit 4 is clear makes the unit write DEPTH words to the array in ascending order from the base, one per clock. Each word is the snapshot value, replaced by the last data written to that word.
- R8: A confirm of any other value, or of 0xD0 while status bit 4 is set, discards the buffer: no array write follows, and the unit returns to idle.
- R9: `status` bit 7 is 1 exactly when the unit is not busy (snapshot or write-back), and bit 4 holds the programming error. All other bits read 0. Bit 4 stays set until `stat_clr`; a new error in the same cycle wins over the clear.
- R10: Bus writes during the snapshot or the write-back are ignored. They change neither the sequence nor the buffer nor the error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Bus write word address |
| bus_wdata | input | BUS_W | Bus write data |
| ro_lock | input | 1 | Array is read-only; data writes are refused |
| stat_clr | input | 1 | Clears the programming-error status bit |
| arr_re | output | 1 | Array read request; data returns one cycle later |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | BUS_W | Array write data |
| arr_rdata | input | BUS_W | Array read data, registered |
| status | output | 8 | Status byte: bit 7 ready, bit 4 programming error |
| seq_idle | output | 1 | No sequence active; the decoder may return to array reads |

## Verification
The assertions take for granted that the array answers a read exactly one cycle after `arr_re`. They also assume that `stat_clr` and `ro_lock` change only between bus writes and not during a write-back whose outcome depends on them. The stimulus meets both: the bench's array model registers its read data on every requested read, and the bench drives `ro_lock` and `stat_clr` only while the unit is idle. The stimulus still sends deliberate bus writes during a snapshot, so that the claim that such writes are ignored is exercised.

// File: rtl/fwb_pkg.sv
// Package for the flash write-buffer program unit.
// Holds the sequence phase type, the opcodes the unit recognises and
// the block-size rule. It assumes byte-multiple bus widths.
package fwb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_COUNT   = 3'd1,
        PH_SNAP    = 3'd2,
        PH_DRAIN   = 3'd3,
        PH_FILL    = 3'd4,
        PH_CONFIRM = 3'd5,
        PH_COMMIT  = 3'd6
    } phase_t;

    localparam logic [7:0] OP_BUF_PROG = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;

    // log2 of the per-device block size in bytes for a given bank width
    function automatic int blk_log2(input int bank_bytes);
        return (bank_bytes == 1) ? 8 : 11;
    endfunction

endpackage

// File: rtl/fwb_store.sv
// Shadow block buffer: one synchronous write port, one combinational read port.
// Assumes the caller never needs reset contents; every word is written by the
// snapshot before it is read.
module fwb_store #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] mem_q [DEPTH];

    // store one word per cycle
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // read the word addressed by the commit walk
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fwb_window.sv
// Block window decode: tells whether a bus address falls in the buffered
// block and gives its word index inside that block. Assumes the base has its
// low IDX_W bits cleared.
module fwb_window #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              in_blk,
    output logic [IDX_W-1:0]  idx
);

    // compare the block-number bits only
    always_comb begin
        in_blk = (addr[ADDR_W-1:IDX_W] == base[ADDR_W-1:IDX_W]);
        idx    = addr[IDX_W-1:0];
    end

endmodule

// File: rtl/fwb_ctrl.sv
// Sequence controller for the buffered-program unit. It walks idle, count,
// snapshot, drain, fill, confirm and commit. It drives the array port and the
// buffer write port and keeps the sticky programming error. It assumes the
// array returns read data one cycle after arr_re.
module fwb_ctrl
    import fwb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BUS_W  = 8,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              ro_lock,
    input  logic              stat_clr,
    input  logic              in_blk,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [BUS_W-1:0]  arr_rdata,
    output logic              arr_re,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_waddr,
    output logic [BUS_W-1:0]  buf_wdata,
    output logic [IDX_W-1:0]  walk_idx,
    output logic [ADDR_W-1:0] base,
    output logic              busy,
    output logic              err,
    output logic              seq_idle
);

    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(DEPTH - 1);

    phase_t             ph_q;
    logic [ADDR_W-1:0]  base_q;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               err_q;
    logic               fill_v_q;
    logic [IDX_W-1:0]   fill_idx_q;

    logic fill_wr, data_ok, data_bad;

    // classify a bus write arriving in the fill phase
    always_comb begin
        fill_wr  = (ph_q == PH_FILL) && bus_we;
        data_ok  = fill_wr && in_blk && !ro_lock;
        data_bad = fill_wr && !(in_blk && !ro_lock);
    end

    // sequence phase, block base, walk index and remaining count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            base_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (bus_we && bus_wdata[7:0] == OP_BUF_PROG) begin
                        ph_q <= PH_COUNT;
                    end
                end
                PH_COUNT: begin
                    if (bus_we) begin
                        cnt_q  <= bus_wdata[CNT_W-1:0];
                        base_q <= bus_addr & BLK_MASK;
                        idx_q  <= '0;
                        ph_q   <= PH_SNAP;
                    end
                end
                PH_SNAP: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_LAST) begin
                        ph_q <= PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    ph_q <= PH_FILL;
                end
                PH_FILL: begin
                    if (bus_we) begin
                        if (cnt_q == '0) begin
                            ph_q <= PH_CONFIRM;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                PH_CONFIRM: begin
                    if (bus_we) begin
                        idx_q <= '0;
                        if (bus_wdata[7:0] == OP_CONFIRM && !err_q) begin
                            ph_q <= PH_COMMIT;
                        end else begin
                            ph_q <= PH_IDLE;
                        end
                    end
                end
                PH_COMMIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_LAST) begin
                        ph_q <= PH_IDLE;
                    end
                end
                default: begin
                    ph_q <= PH_IDLE;
                end
            endcase
        end
    end

    // snapshot capture pipeline, one stage behind the array read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_v_q   <= 1'b0;
            fill_idx_q <= '0;
        end else begin
            fill_v_q   <= (ph_q == PH_SNAP);
            fill_idx_q <= idx_q;
        end
    end

    // sticky programming error; a new error wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (data_bad) begin
            err_q <= 1'b1;
        end else if (stat_clr) begin
            err_q <= 1'b0;
        end
    end

    // buffer write port: snapshot words first, data writes otherwise
    always_comb begin
        buf_we    = 1'b0;
        buf_waddr = win_idx;
        buf_wdata = bus_wdata;
        if (fill_v_q) begin
            buf_we    = 1'b1;
            buf_waddr = fill_idx_q;
            buf_wdata = arr_rdata;
        end else if (data_ok) begin
            buf_we = 1'b1;
        end
    end

    // array port and status outputs from registered state only
    always_comb begin
        arr_re   = (ph_q == PH_SNAP);
        arr_we   = (ph_q == PH_COMMIT);
        arr_addr = base_q | {{(ADDR_W-IDX_W){1'b0}}, idx_q};
        walk_idx = idx_q;
        base     = base_q;
        busy     = (ph_q == PH_SNAP) || (ph_q == PH_DRAIN) || (ph_q == PH_COMMIT);
        err      = err_q;
        seq_idle = (ph_q == PH_IDLE);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (!arr_re && !arr_we)); // R1

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_re && arr_we)); // R3

    AST_SNAP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_re && $past(arr_re)) |-> (arr_addr == ADDR_W'($past(arr_addr) + 1'b1))); // R3

    AST_COMMIT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr == ADDR_W'($past(arr_addr) + 1'b1))); // R7

    AST_COMMIT_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_we) |-> !err); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err) && !$past(stat_clr)) |-> err); // R9

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && !stat_clr) |=> $stable(err)); // R10

    AST_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_re || arr_we) |-> busy); // R9

endmodule

// File: rtl/flash_wbuf_prog.sv
// Flash write-buffer program unit (top). It stages one aligned block of the
// array in a shadow buffer, merges count+1 data writes into it and writes it
// back only on a clean 0xD0 confirm. It assumes a word-addressed bus, a
// one-cycle array read latency and a power-of-two device count.
module flash_wbuf_prog
    import fwb_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int BANK_BYTES = 1,
    parameter int DEV_BYTES  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [8*BANK_BYTES-1:0] bus_wdata,
    input  logic                    ro_lock,
    input  logic                    stat_clr,
    output logic                    arr_re,
    output logic                    arr_we,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [8*BANK_BYTES-1:0] arr_wdata,
    input  logic [8*BANK_BYTES-1:0] arr_rdata,
    output logic [7:0]              status,
    output logic                    seq_idle
);

    localparam int BUS_W     = 8 * BANK_BYTES;
    localparam int NUM_DEV   = (DEV_BYTES == 0) ? 1 : BANK_BYTES / DEV_BYTES;
    localparam int CNT_W     = 8 * ((DEV_BYTES == 0) ? BANK_BYTES : DEV_BYTES);
    localparam int BLK_BYTES = (1 << blk_log2(BANK_BYTES)) * NUM_DEV;
    localparam int DEPTH     = BLK_BYTES / BANK_BYTES;
    localparam int IDX_W     = $clog2(DEPTH);

    logic              in_blk;
    logic [IDX_W-1:0]  win_idx;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_waddr;
    logic [BUS_W-1:0]  buf_wdata;
    logic [IDX_W-1:0]  walk_idx;
    logic [ADDR_W-1:0] base;
    logic              busy;
    logic              err;

    fwb_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_window (
        .addr   (bus_addr),
        .base   (base),
        .in_blk (in_blk),
        .idx    (win_idx)
    );

    fwb_ctrl #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ro_lock   (ro_lock),
        .stat_clr  (stat_clr),
        .in_blk    (in_blk),
        .win_idx   (win_idx),
        .arr_rdata (arr_rdata),
        .arr_re    (arr_re),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_wdata (buf_wdata),
        .walk_idx  (walk_idx),
        .base      (base),
        .busy      (busy),
        .err       (err),
        .seq_idle  (seq_idle)
    );

    fwb_store #(.W(BUS_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (walk_idx),
        .rdata (arr_wdata)
    );

    // status byte: bit 7 ready, bit 4 programming error
    always_comb begin
        status = {~busy, 2'b00, err, 4'b0000};
    end

endmodule

// File: tb/flash_wbuf_prog_tb.sv
module flash_wbuf_prog_tb;

    localparam int ADDR_W = 10;
    localparam int DEPTH  = 256;
    localparam int MSIZE  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              ro_lock = 1'b0;
    logic              stat_clr = 1'b0;
    logic              arr_re, arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;
    logic [7:0]        arr_rdata = '0;
    logic [7:0]        status;
    logic              seq_idle;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    flash_wbuf_prog #(.ADDR_W(ADDR_W), .BANK_BYTES(1), .DEV_BYTES(1)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ro_lock   (ro_lock),
        .stat_clr  (stat_clr),
        .arr_re    (arr_re),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .arr_rdata (arr_rdata),
        .status    (status),
        .seq_idle  (seq_idle)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // array model with one-cycle registered reads
    logic [7:0] mem [MSIZE];
    initial begin
        for (int i = 0; i < MSIZE; i++) mem[i] = init_val(i);
    end
    always @(posedge clk) begin
        if (arr_re) arr_rdata <= mem[arr_addr];
        if (arr_we) mem[arr_addr] <= arr_wdata;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 count, 2 snapshot, 3 data, 4 confirm, 5 commit
    int m_ph = 0;
    int m_k = 0;
    int m_cnt = 0;
    int m_base = 0;
    int m_err = 0;
    int m_buf [DEPTH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_k = 0; m_cnt = 0; m_base = 0; m_err = 0;
        end else begin
            int setf;
            setf = 0;
            case (m_ph)
                0: if (bus_we && bus_wdata == 8'hE8) m_ph = 1;
                1: if (bus_we) begin
                       m_cnt  = int'(bus_wdata);
                       m_base = (int'(bus_addr) / DEPTH) * DEPTH;
                       for (int j = 0; j < DEPTH; j++) m_buf[j] = int'(mem[m_base + j]);
                       m_k  = 0;
                       m_ph = 2;
                   end
                2: begin
                       m_k++;
                       if (m_k == DEPTH + 1) m_ph = 3;
                   end
                3: if (bus_we) begin
                       if (ro_lock || (int'(bus_addr) / DEPTH != m_base / DEPTH)) setf = 1;
                       else m_buf[int'(bus_addr) % DEPTH] = int'(bus_wdata);
                       if (m_cnt == 0) m_ph = 4;
                       else m_cnt--;
                   end
                4: if (bus_we) begin
                       if (bus_wdata == 8'hD0 && m_err == 0) begin
                           m_ph = 5; m_k = 0;
                       end else begin
                           m_ph = 0;
                       end
                   end
                5: begin
                       m_k++;
                       if (m_k == DEPTH) m_ph = 0;
                   end
                default: m_ph = 0;
            endcase
            if (setf != 0) m_err = 1;
            else if (stat_clr) m_err = 0;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_busy, e_re, e_we;
            int e_stat;
            e_busy = (m_ph == 2) || (m_ph == 5);
            e_re   = (m_ph == 2) && (m_k < DEPTH);
            e_we   = (m_ph == 5);
            e_stat = (e_busy ? 0 : 8'h80) | (m_err != 0 ? 8'h10 : 0);
            chk(seq_idle == (m_ph == 0), "R2 seq_idle", int'(seq_idle), int'(m_ph == 0));
            chk(int'(status) == e_stat, "R9 status", int'(status), e_stat);
            chk(arr_re == e_re, "R3 arr_re", int'(arr_re), int'(e_re));
            chk(arr_we == e_we, "R7 arr_we", int'(arr_we), int'(e_we));
            if (e_re || e_we)
                chk(int'(arr_addr) == m_base + m_k, "R3 arr_addr", int'(arr_addr), m_base + m_k);
            if (e_we)
                chk(int'(arr_wdata) == m_buf[m_k], "R7 arr_wdata", int'(arr_wdata), m_buf[m_k]);
        end
    end

    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(a);
        bus_wdata = 8'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_ready();
        while (status[7] == 1'b0) @(negedge clk);
    endtask

    task automatic clear_err();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h80, "R1 status", int'(status), 8'h80);
        chk(seq_idle == 1'b1 && !arr_re && !arr_we, "R1 idle quiet", int'(seq_idle), 1);

        // R2 a non-opcode write while idle does nothing
        bus_wr(12'h040, 8'h55);
        @(negedge clk);
        chk(seq_idle == 1'b1, "R2 non-E8 ignored", int'(seq_idle), 1);

        // R3 R7 good sequence: count 2 at 0x1A5, block base 0x100
        bus_wr(12'h1A5, 8'hE8);
        bus_wr(12'h1A5, 8'h02);
        chk(status[7] == 1'b0, "R3 busy in snapshot", int'(status), 0);
        wait_ready();
        bus_wr(12'h105, 8'hAA);
        bus_wr(12'h1FF, 8'hBB);
        bus_wr(12'h100, 8'hCC);
        bus_wr(12'h100, 8'hD0);
        wait_ready();
        chk(mem[12'h105] == 8'hAA, "R7 commit 105", int'(mem[12'h105]), 8'hAA);
        chk(mem[12'h1FF] == 8'hBB, "R7 commit 1FF", int'(mem[12'h1FF]), 8'hBB);
        chk(mem[12'h100] == 8'hCC, "R7 commit 100", int'(mem[12'h100]), 8'hCC);
        chk(mem[12'h106] == init_val(12'h106), "R7 untouched word kept",
            int'(mem[12'h106]), int'(init_val(12'h106)));

        // R5 out-of-block write sets bit 4; R8 D0 with error discards
        bus_wr(12'h010, 8'hE8);
        bus_wr(12'h010, 8'h01);
        wait_ready();
        bus_wr(12'h120, 8'h11);
        bus_wr(12'h020, 8'h22);
        chk(status[4] == 1'b1, "R5 range error bit", int'(status), 8'h90);
        bus_wr(12'h000, 8'hD0);
        repeat (3) @(negedge clk);
        chk(seq_idle == 1'b1 && !arr_we, "R8 discard on error", int'(seq_idle), 1);
        chk(mem[12'h020] == init_val(12'h020), "R8 no write back",
            int'(mem[12'h020]), int'(init_val(12'h020)));
        chk(mem[12'h120] == init_val(12'h120), "R5 out-of-block not stored",
            int'(mem[12'h120]), int'(init_val(12'h120)));

        // R9 clear
        clear_err();
        chk(status == 8'h80, "R9 cleared", int'(status), 8'h80);

        // R6 read-only refuses data
        ro_lock = 1'b1;
        bus_wr(12'h200, 8'hE8);
        bus_wr(12'h200, 8'h00);
        wait_ready();
        bus_wr(12'h210, 8'h33);
        chk(status[4] == 1'b1, "R6 ro error bit", int'(status), 8'h90);
        bus_wr(12'h210, 8'hD0);
        repeat (3) @(negedge clk);
        chk(mem[12'h210] == init_val(12'h210), "R6 ro not stored",
            int'(mem[12'h210]), int'(init_val(12'h210)));
        ro_lock = 1'b0;
        clear_err();

        // R4 a data value of D0 inside the count is still data
        bus_wr(12'h300, 8'hE8);
        bus_wr(12'h300, 8'h03);
        wait_ready();
        bus_wr(12'h301, 8'h01);
        bus_wr(12'h302, 8'h02);
        bus_wr(12'h303, 8'h03);
        bus_wr(12'h304, 8'hD0);
        chk(seq_idle == 1'b0 && status[7] == 1'b1, "R4 fourth write is data",
            int'(status), 8'h80);
        bus_wr(12'h300, 8'hD0);
        wait_ready();
        chk(mem[12'h304] == 8'hD0, "R4 D0 stored as data", int'(mem[12'h304]), 8'hD0);
        chk(mem[12'h303] == 8'h03, "R4 last counted word", int'(mem[12'h303]), 8'h03);

        // R8 wrong confirm value discards
        bus_wr(12'h000, 8'hE8);
        bus_wr(12'h000, 8'h00);
        wait_ready();
        bus_wr(12'h005, 8'h77);
        bus_wr(12'h000, 8'h20);
        repeat (3) @(negedge clk);
        chk(seq_idle == 1'b1 && status == 8'h80, "R8 bad confirm to idle", int'(status), 8'h80);
        chk(mem[12'h005] == init_val(12'h005), "R8 bad confirm no write",
            int'(mem[12'h005]), int'(init_val(12'h005)));

        // R10 write during snapshot is ignored
        bus_wr(12'h080, 8'hE8);
        bus_wr(12'h080, 8'h00);
        bus_wr(12'h081, 8'h99);
        chk(status[4] == 1'b0, "R10 no error from busy write", int'(status), 0);
        wait_ready();
        bus_wr(12'h082, 8'h44);
        bus_wr(12'h080, 8'hD0);
        wait_ready();
        chk(mem[12'h081] == init_val(12'h081), "R10 busy write dropped",
            int'(mem[12'h081]), int'(init_val(12'h081)));
        chk(mem[12'h082] == 8'h44, "R10 later write kept", int'(mem[12'h082]), 8'h44);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule